// File: doc/BRIEF.md
# Bidirectional Semaphore Interrupt Unit

This block holds two banks of single-bit semaphore flags shared between a host processor and a DSP. The host writes a whole word to the outbound bank. The bits of that word are driven out as a vector that the DSP side watches. The inbound bank is raised by the DSP through per-bit set strobes. The host cannot write the inbound bank. It can only clear bits in it, through a separate write-one-to-clear port.

A host-owned mask decides which inbound flags may interrupt the host. A mask bit of 1 blocks its flag and a 0 lets it through. Every flag that is set and not blocked feeds one OR term. That term is shown at once as a single bit of a status word and, in the default variant, drives a registered interrupt line one clock later. The number of flags, the status word width, the position of the summary bit, the mask reset value and the interrupt variant are all parameters.

Top module: `sem_unit`

## Requirements
- R1: After reset, the outbound flags and inbound flags are all 0, the mask equals `MASK_RST` (default all ones), and both the status word and `irq_o` are 0.
- R2: A host write (`h2d_we` = 1) loads `h2d_wdata` into the outbound flags, which appear on `h2d_flags_o` after that clock edge. Without a write, the outbound flags hold their value.
- R3: A 1 on bit n of `dsp_set_i` sets inbound flag n at the next edge. The flag stays 1 until it is cleared.
- R4: When `clr_we` = 1, each 1 in `clr_wdata` clears the matching inbound flag and each 0 leaves its flag unchanged.
- R5: If bit n is both set by the DSP and cleared by the host in the same cycle, the flag ends up 1.
- R6: A host mask write (`mask_we` = 1) loads `mask_wdata` into the mask at the next edge. Mask bit n = 1 disables flag n as an interrupt source, and 0 enables it.
- R7: Bit `STS_POS` (default 9) of `sts_o` equals the OR over all n of (inbound flag n AND NOT mask n), with no added delay. All other bits of `sts_o` read 0.
- R8: With the registered variant (default), `irq_o` equals the value of status bit `STS_POS` from one cycle earlier.
- R9: The host cannot write the inbound flags. Outbound writes and mask writes leave them unchanged, and with no set strobe and no clear write they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h2d_we | input | 1 | Host write strobe for the outbound flags |
| h2d_wdata | input | N | Word written to the outbound flags |
| h2d_flags_o | output | N | Outbound flags, visible to the DSP |
| dsp_set_i | input | N | DSP per-bit set strobes for the inbound flags |
| clr_we | input | 1 | Host write strobe for the clear port |
| clr_wdata | input | N | Write-one-to-clear bits for the inbound flags |
| mask_we | input | 1 | Host write strobe for the mask |
| mask_wdata | input | N | Mask word (1 disables a flag) |
| d2h_flags_o | output | N | Inbound flags, readable by the host |
| mask_o | output | N | Current mask |
| sts_o | output | STS_W | Status word with the semaphore summary at bit STS_POS |
| irq_o | output | 1 | Host interrupt |

## Verification
All flag and mask writes, set strobes and clears take effect at the first rising edge after they are applied. The status bit follows the flags within that same cycle, and the interrupt line follows one edge later. The bench applies its stimulus on a falling edge and compares every output on the next falling edge. At that point it expects the new register contents and the matching status bit, and it expects `irq_o` to equal the summary computed from the state one cycle earlier. Directed cases cover the set-versus-clear collision, clear with zero bits, mask blocking, and host writes that must leave the inbound flags untouched. Random cycles with sparse set strobes cover the rest.

// File: rtl/sem_pkg.sv
package sem_pkg;
   typedef enum logic {
      IRQ_COMB       = 1'b0,
      IRQ_REGISTERED = 1'b1
   } irq_mode_e;
endpackage

// File: rtl/sem_wreg.sv
module sem_wreg #(
   parameter int          W   = 16,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= d;
   end
endmodule

// File: rtl/sem_flag_bank.sv
module sem_flag_bank #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_en_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flags_o
);
   // one flop per flag; set has priority over clear so no event is lost
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     q <= 1'b0;
         else if (set_i[i])              q <= 1'b1;
         else if (clr_en_i && clr_i[i])  q <= 1'b0;
      end
      assign flags_o[i] = q;
   end
endmodule

// File: rtl/sem_irq_gen.sv
module sem_irq_gen #(
   parameter int                N    = 16,
   parameter sem_pkg::irq_mode_e MODE = sem_pkg::IRQ_REGISTERED
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags_i,
   input  logic [N-1:0] mask_i,
   output logic         pend_o,
   output logic         irq_o
);
   logic [N-1:0] live;
   assign live   = flags_i & ~mask_i;
   assign pend_o = |live;

   if (MODE == sem_pkg::IRQ_REGISTERED) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pend_o;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      assign irq_o = pend_o;
   end
endmodule

// File: rtl/sem_unit.sv
module sem_unit #(
   parameter int                 N        = 16,
   parameter int                 STS_W    = 16,
   parameter int                 STS_POS  = 9,
   parameter logic [N-1:0]       MASK_RST = '1,
   parameter sem_pkg::irq_mode_e IRQ_MODE = sem_pkg::IRQ_REGISTERED
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             h2d_we,
   input  logic [N-1:0]     h2d_wdata,
   output logic [N-1:0]     h2d_flags_o,
   input  logic [N-1:0]     dsp_set_i,
   input  logic             clr_we,
   input  logic [N-1:0]     clr_wdata,
   input  logic             mask_we,
   input  logic [N-1:0]     mask_wdata,
   output logic [N-1:0]     d2h_flags_o,
   output logic [N-1:0]     mask_o,
   output logic [STS_W-1:0] sts_o,
   output logic             irq_o
);
   localparam int PosW = (STS_W > 1) ? $clog2(STS_W) : 1;

   if (N < 1) begin : g_bad_n
      $error("sem_unit: N must be at least 1");
   end
   if (STS_POS < 0 || STS_POS >= STS_W) begin : g_bad_pos
      $error("sem_unit: STS_POS must lie inside the status word");
   end

   logic pend;

   sem_wreg #(.W(N), .RST('0)) i_h2d (
      .clk(clk), .rst_n(rst_n), .we(h2d_we), .d(h2d_wdata), .q(h2d_flags_o)
   );

   sem_wreg #(.W(N), .RST(MASK_RST)) i_mask (
      .clk(clk), .rst_n(rst_n), .we(mask_we), .d(mask_wdata), .q(mask_o)
   );

   sem_flag_bank #(.N(N)) i_d2h (
      .clk(clk), .rst_n(rst_n), .set_i(dsp_set_i),
      .clr_en_i(clr_we), .clr_i(clr_wdata), .flags_o(d2h_flags_o)
   );

   sem_irq_gen #(.N(N), .MODE(IRQ_MODE)) i_irq (
      .clk(clk), .rst_n(rst_n), .flags_i(d2h_flags_o), .mask_i(mask_o),
      .pend_o(pend), .irq_o(irq_o)
   );

   always_comb begin
      sts_o = '0;
      sts_o[PosW'(STS_POS)] = pend;
   end
endmodule

// File: rtl/sem_unit_chk.sv
module sem_unit_chk #(
   parameter int                 N        = 16,
   parameter int                 STS_W    = 16,
   parameter int                 STS_POS  = 9,
   parameter sem_pkg::irq_mode_e IRQ_MODE = sem_pkg::IRQ_REGISTERED
) (
   input logic             clk,
   input logic             rst_n,
   input logic             h2d_we,
   input logic [N-1:0]     h2d_wdata,
   input logic [N-1:0]     h2d_flags_o,
   input logic [N-1:0]     dsp_set_i,
   input logic             clr_we,
   input logic [N-1:0]     clr_wdata,
   input logic             mask_we,
   input logic [N-1:0]     mask_wdata,
   input logic [N-1:0]     d2h_flags_o,
   input logic [N-1:0]     mask_o,
   input logic [STS_W-1:0] sts_o,
   input logic             irq_o
);
   localparam logic [STS_W-1:0] SumBit = STS_W'(1) << STS_POS;

   assert_h2d_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      h2d_we |=> h2d_flags_o == $past(h2d_wdata));

   assert_h2d_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !h2d_we |=> $stable(h2d_flags_o));

   assert_set_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_set_i != '0) |=> ((d2h_flags_o & $past(dsp_set_i)) == $past(dsp_set_i)));

   // R5: set bits are excluded, so a colliding bit is covered by R3 above
   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((d2h_flags_o & $past(clr_wdata & ~dsp_set_i)) == '0));

   assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> mask_o == $past(mask_wdata));

   assert_sts_other_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_o & ~SumBit) == '0);

   assert_readonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_set_i == '0 && !clr_we) |=> $stable(d2h_flags_o));

   if (IRQ_MODE == sem_pkg::IRQ_REGISTERED) begin : g_reg_chk
      assert_irq_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> irq_o == $past(sts_o[STS_POS]));
   end
endmodule

bind sem_unit sem_unit_chk #(
   .N(N), .STS_W(STS_W), .STS_POS(STS_POS), .IRQ_MODE(IRQ_MODE)
) i_chk (
   .clk(clk), .rst_n(rst_n), .h2d_we(h2d_we), .h2d_wdata(h2d_wdata),
   .h2d_flags_o(h2d_flags_o), .dsp_set_i(dsp_set_i), .clr_we(clr_we),
   .clr_wdata(clr_wdata), .mask_we(mask_we), .mask_wdata(mask_wdata),
   .d2h_flags_o(d2h_flags_o), .mask_o(mask_o), .sts_o(sts_o), .irq_o(irq_o)
);

// File: tb/test_sem_unit.sv
`timescale 1ns/1ps
module test_sem_unit;
   localparam int N = 16;
   localparam int STS_W = 16;
   localparam int STS_POS = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic h2d_we = 1'b0, clr_we = 1'b0, mask_we = 1'b0;
   logic [N-1:0] h2d_wdata = '0, dsp_set_i = '0, clr_wdata = '0, mask_wdata = '0;
   logic [N-1:0] h2d_flags_o, d2h_flags_o, mask_o;
   logic [STS_W-1:0] sts_o;
   logic irq_o;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [N-1:0] m_h2d, m_d2h, m_mask;
   logic m_irq;

   always #2 clk = ~clk;

   sem_unit i_sem_unit (
      .clk(clk), .rst_n(rst_n), .h2d_we(h2d_we), .h2d_wdata(h2d_wdata),
      .h2d_flags_o(h2d_flags_o), .dsp_set_i(dsp_set_i), .clr_we(clr_we),
      .clr_wdata(clr_wdata), .mask_we(mask_we), .mask_wdata(mask_wdata),
      .d2h_flags_o(d2h_flags_o), .mask_o(mask_o), .sts_o(sts_o), .irq_o(irq_o)
   );

   function automatic logic pend_of(logic [N-1:0] f, logic [N-1:0] m);
      return |(f & ~m);
   endfunction

   function automatic logic [STS_W-1:0] sts_of(logic [N-1:0] f, logic [N-1:0] m);
      logic [STS_W-1:0] s = '0;
      s[STS_POS] = pend_of(f, m);
      return s;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      chk("R2 outbound flags", 32'(h2d_flags_o), 32'(m_h2d));
      chk("R3/R4/R5/R9 inbound flags", 32'(d2h_flags_o), 32'(m_d2h));
      chk("R6 mask", 32'(mask_o), 32'(m_mask));
      chk("R7 status word", 32'(sts_o), 32'(sts_of(m_d2h, m_mask)));
      chk("R8 interrupt", 32'(irq_o), 32'(m_irq));
   endtask

   // drive one cycle of stimulus just after a falling edge, check at the next one
   task automatic step(logic hw, logic [N-1:0] hd, logic [N-1:0] st,
                       logic cw, logic [N-1:0] cd, logic mw, logic [N-1:0] md);
      h2d_we = hw; h2d_wdata = hd; dsp_set_i = st;
      clr_we = cw; clr_wdata = cd; mask_we = mw; mask_wdata = md;
      m_irq = pend_of(m_d2h, m_mask);
      if (hw) m_h2d = hd;
      if (mw) m_mask = md;
      m_d2h = (cw ? (m_d2h & ~cd) : m_d2h) | st;
      @(negedge clk);
      check_all();
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] seed;
      seed = $urandom(32'h5e3a_0911);
      m_h2d = '0; m_d2h = '0; m_mask = '1; m_irq = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values
      check_all();
      @(negedge clk);
      check_all();

      // R6/R7: flag raised under full mask, no interrupt
      step(1'b0, '0, 16'h0004, 1'b0, '0, 1'b0, '0);
      chk("R6 masked flag gives no status", 32'(sts_o[STS_POS]), 32'd0);
      // R6: unmask bit 2, status follows at once, irq one cycle later (R8)
      step(1'b0, '0, '0, 1'b0, '0, 1'b1, 16'hFFFB);
      chk("R7 status bit up", 32'(sts_o[STS_POS]), 32'd1);
      chk("R8 irq still low", 32'(irq_o), 32'd0);
      step(1'b0, '0, '0, 1'b0, '0, 1'b0, '0);
      chk("R8 irq up", 32'(irq_o), 32'd1);
      // R9: host writes to outbound flags and mask leave inbound alone
      step(1'b1, 16'hA5C3, '0, 1'b0, '0, 1'b1, 16'h0000);
      chk("R9 inbound unchanged", 32'(d2h_flags_o), 32'h0004);
      chk("R2 outbound loaded", 32'(h2d_flags_o), 32'hA5C3);
      // R4: clear with zero bits changes nothing, then clear bit 2
      step(1'b0, '0, '0, 1'b1, 16'hFFFB, 1'b0, '0);
      chk("R4 zero bits keep flag", 32'(d2h_flags_o), 32'h0004);
      step(1'b0, '0, '0, 1'b1, 16'h0004, 1'b0, '0);
      chk("R4 cleared", 32'(d2h_flags_o), 32'h0000);
      // R5: set and clear collide on bit 15, clear alone hits bit 0
      step(1'b0, '0, 16'h0001, 1'b0, '0, 1'b0, '0);
      step(1'b0, '0, 16'h8000, 1'b1, 16'h8001, 1'b0, '0);
      chk("R5 set wins", 32'(d2h_flags_o), 32'h8000);
      step(1'b0, '0, '0, 1'b0, '0, 1'b0, '0);

      // random phase
      for (int k = 0; k < 600; k++) begin
         logic [N-1:0] st;
         st = N'($urandom & $urandom & $urandom);
         step(($urandom % 4) == 0, N'($urandom), st,
              ($urandom % 3) == 0, N'($urandom),
              ($urandom % 5) == 0, N'($urandom | $urandom));
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule